// File: doc/BRIEF.md
# Link Fault Indicator Combiner

This block gives the link status for each receive channel of a multi-channel serial receiver. Each channel has four quality flags: signal amplitude good, transition density good, frequency inside the tracking window, and channel enabled. The block combines them into one active-low link-health output per channel. All flags and the loopback control may come from other clock domains, so each goes through a two-flop synchronizer. The combined result is then registered in the receive interface clock domain.

When local loopback is on, the amplitude comparator and the enable flag take no part in the result. Only the density and frequency flags are used, and they describe the transmit data that is looped back. Loopback also holds every transmit serial output at a steady logic one, so a diagnostic pattern never reaches the far end of the link.

Top module: `linkFaultCombiner`

## Requirements
- R1: With loopback off, `faultN[c]` is 1 when `ampOk[c]`, `densOk[c]`, `freqOk[c]` and `chanEn[c]` are all 1.
- R2: With loopback off, a 0 on any one of the four flags of channel c drives `faultN[c]` to 0. Each channel is unaffected by the flags of the other channels.
- R3: A flag change shows on `faultN` at the third rising edge of `clk` after the change, and not before. This latency is two synchronizer stages plus the output register.
- R4: While `rstN` is 0, `faultN` is all zeros. After reset is released, `faultN` stays 0 until good flags have passed the synchronizer, which takes three edges.
- R5: With loopback on, `faultN[c]` equals `densOk[c] & freqOk[c]`. The flags `ampOk[c]` and `chanEn[c]` have no effect.
- R6: With loopback on, `txSerOut` is all ones. The forcing starts at the second rising edge after `loopEn` rises. Its effect on `faultN` follows the three-edge latency of R3.
- R7: With loopback off, including during reset, `txSerOut` equals `txSerIn` without any register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected receive interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loopEn | input | 1 | Local loopback request, asynchronous |
| ampOk | input | NUM_CH | Amplitude good, one bit per channel |
| densOk | input | NUM_CH | Transition density good, per channel |
| freqOk | input | NUM_CH | Frequency inside the window, per channel |
| chanEn | input | NUM_CH | Receive channel enable, per channel |
| txSerIn | input | NUM_CH | Transmit serial bits from the serializers |
| txSerOut | output | NUM_CH | Transmit serial bits to the line drivers |
| faultN | output | NUM_CH | Link fault indicator, active low |

## Verification
A flag change is due on `faultN` at the third rising edge after it is driven, and a `loopEn` change is due on `txSerOut` at the second. `txSerIn` passes through in the same cycle. The bench drives inputs on falling edges and samples on falling edges. The table vectors are held for four edges before they are compared, so every path has settled. Directed tests then sample after each single edge to show that no result appears before its due edge.

// File: rtl/lfcPkg.sv
package lfcPkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic qualLoop;   // use only density and frequency flags
    logic forceMark;  // hold transmit outputs at logic one
  } lfcStrobe_t;
endpackage

// File: rtl/lfcSync.sv
module lfcSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lfcControl.sv
module lfcControl
  import lfcPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopEn,
  output lfcStrobe_t strobe
);
  logic loopSync;

  lfcSync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_loopSync (
    .clk (clk),
    .rstN(rstN),
    .din (loopEn),
    .dout(loopSync)
  );

  always_comb begin
    strobe.qualLoop  = loopSync;
    strobe.forceMark = loopSync;
  end
endmodule

// File: rtl/lfcDatapath.sv
module lfcDatapath
  import lfcPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfcStrobe_t        strobe,
  input  logic [NUM_CH-1:0] ampOk,
  input  logic [NUM_CH-1:0] densOk,
  input  logic [NUM_CH-1:0] freqOk,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] txSerIn,
  output logic [NUM_CH-1:0] txSerOut,
  output logic [NUM_CH-1:0] faultN
);
  localparam int FLAGS = 4;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [FLAGS-1:0] rawFlags;
    logic [FLAGS-1:0] syncFlags;
    logic             linkGood;
    logic             faultQ;

    assign rawFlags = {ampOk[ch], densOk[ch], freqOk[ch], chanEn[ch]};

    lfcSync #(.WIDTH(FLAGS), .STAGES(SYNC_STAGES)) i_flagSync (
      .clk (clk),
      .rstN(rstN),
      .din (rawFlags),
      .dout(syncFlags)
    );

    // syncFlags: [3] amplitude, [2] density, [1] frequency, [0] enable
    always_comb begin
      if (strobe.qualLoop) linkGood = syncFlags[2] & syncFlags[1];
      else                 linkGood = &syncFlags;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) faultQ <= 1'b0;
      else       faultQ <= linkGood;
    end

    assign faultN[ch] = faultQ;
  end

  assign txSerOut = strobe.forceMark ? '1 : txSerIn;
endmodule

// File: rtl/linkFaultCombiner.sv
module linkFaultCombiner
  import lfcPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopEn,
  input  logic [NUM_CH-1:0] ampOk,
  input  logic [NUM_CH-1:0] densOk,
  input  logic [NUM_CH-1:0] freqOk,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] txSerIn,
  output logic [NUM_CH-1:0] txSerOut,
  output logic [NUM_CH-1:0] faultN
);
  lfcStrobe_t strobe;

  lfcControl #(.SYNC_STAGES(SYNC_STAGES)) i_control (
    .clk   (clk),
    .rstN  (rstN),
    .loopEn(loopEn),
    .strobe(strobe)
  );

  lfcDatapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ampOk   (ampOk),
    .densOk  (densOk),
    .freqOk  (freqOk),
    .chanEn  (chanEn),
    .txSerIn (txSerIn),
    .txSerOut(txSerOut),
    .faultN  (faultN)
  );
endmodule

// File: rtl/lfcChecker.sv
module lfcChecker #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              loopEn,
  input logic [NUM_CH-1:0] ampOk,
  input logic [NUM_CH-1:0] densOk,
  input logic [NUM_CH-1:0] freqOk,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] txSerIn,
  input logic [NUM_CH-1:0] txSerOut,
  input logic [NUM_CH-1:0] faultN
);
  localparam int DEPTH = SYNC_STAGES + 1;

  // Port history; reset to zero, matching a cleared synchronizer
  logic              loopD [DEPTH];
  logic [NUM_CH-1:0] ampD  [DEPTH];
  logic [NUM_CH-1:0] densD [DEPTH];
  logic [NUM_CH-1:0] freqD [DEPTH];
  logic [NUM_CH-1:0] enD   [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        loopD[i] <= 1'b0; ampD[i] <= '0; densD[i] <= '0;
        freqD[i] <= '0;   enD[i]  <= '0;
      end
    end else begin
      loopD[0] <= loopEn; ampD[0] <= ampOk; densD[0] <= densOk;
      freqD[0] <= freqOk; enD[0]  <= chanEn;
      for (int i = 1; i < DEPTH; i++) begin
        loopD[i] <= loopD[i-1]; ampD[i] <= ampD[i-1]; densD[i] <= densD[i-1];
        freqD[i] <= freqD[i-1]; enD[i]  <= enD[i-1];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_all_good_R1: assert property (@(posedge clk) disable iff (!rstN)
      (!loopD[SYNC_STAGES] && ampD[SYNC_STAGES][ch] && densD[SYNC_STAGES][ch] &&
       freqD[SYNC_STAGES][ch] && enD[SYNC_STAGES][ch]) |-> faultN[ch]);

    assert_any_bad_R2: assert property (@(posedge clk) disable iff (!rstN)
      (!loopD[SYNC_STAGES] && !(ampD[SYNC_STAGES][ch] && densD[SYNC_STAGES][ch] &&
       freqD[SYNC_STAGES][ch] && enD[SYNC_STAGES][ch])) |-> !faultN[ch]);

    assert_loop_qual_R5: assert property (@(posedge clk) disable iff (!rstN)
      loopD[SYNC_STAGES] |->
        (faultN[ch] == (densD[SYNC_STAGES][ch] & freqD[SYNC_STAGES][ch])));
  end

  assert_force_mark_R6: assert property (@(posedge clk) disable iff (!rstN)
    loopD[SYNC_STAGES-1] |-> (txSerOut == '1));

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loopD[SYNC_STAGES-1] |-> (txSerOut == txSerIn));
endmodule

bind linkFaultCombiner lfcChecker #(
  .NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)
) i_lfcChecker (.*);

// File: tb/test_linkFaultCombiner.sv
module test_linkFaultCombiner;
  localparam int NCH  = 4;
  localparam int NVEC = 12;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           loopEn = 1'b0;
  logic [NCH-1:0] ampOk = '0, densOk = '0, freqOk = '0, chanEn = '0, txSerIn = '0;
  logic [NCH-1:0] txSerOut, faultN;

  int  applied = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  linkFaultCombiner #(.NUM_CH(NCH), .SYNC_STAGES(2)) i_linkFaultCombiner (
    .clk(clk), .rstN(rstN), .loopEn(loopEn),
    .ampOk(ampOk), .densOk(densOk), .freqOk(freqOk), .chanEn(chanEn),
    .txSerIn(txSerIn), .txSerOut(txSerOut), .faultN(faultN)
  );

  // {loop, amp, dens, freq, en, txIn, expFaultN, expTxOut}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h5, 4'hF, 4'h5},  // R1 all good
    {1'b0, 4'hE, 4'hF, 4'hF, 4'hF, 4'hA, 4'hE, 4'hA},  // R2 amplitude
    {1'b0, 4'hF, 4'hD, 4'hF, 4'hF, 4'h3, 4'hD, 4'h3},  // R2 density
    {1'b0, 4'hF, 4'hF, 4'hB, 4'hF, 4'hC, 4'hB, 4'hC},  // R2 frequency
    {1'b0, 4'hF, 4'hF, 4'hF, 4'h7, 4'h0, 4'h7, 4'h0},  // R2 enable
    {1'b0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'hF},  // R2 all amp low
    {1'b1, 4'h0, 4'hF, 4'hF, 4'hF, 4'h0, 4'hF, 4'hF},  // R5 amp ignored, R6
    {1'b1, 4'h0, 4'h6, 4'hF, 4'hF, 4'h5, 4'h6, 4'hF},  // R5 density used
    {1'b1, 4'hF, 4'hF, 4'h9, 4'hF, 4'h0, 4'h9, 4'hF},  // R5 frequency used
    {1'b1, 4'hF, 4'hF, 4'hF, 4'h3, 4'hA, 4'hF, 4'hF},  // R5 enable ignored
    {1'b0, 4'h5, 4'hF, 4'hF, 4'hF, 4'h6, 4'h5, 4'h6},  // R7 back to normal
    {1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h9, 4'h0, 4'h9}   // R2 all disabled
  };

  task automatic check(input string req, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic lp, input logic [NCH-1:0] a, d, f, e, t);
    loopEn = lp; ampOk = a; densOk = d; freqOk = f; chanEn = e; txSerIn = t;
  endtask

  initial begin
    // R4: reset state, R7 pass-through during reset
    drive(1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h9);
    waitEdges(3);
    check("R4 faultN in reset", faultN, 4'h0);
    check("R7 txSerOut in reset", txSerOut, 4'h9);

    // R4/R3: release with good flags, result due on third edge
    rstN = 1'b1;
    waitEdges(1);
    check("R4 faultN after edge 1", faultN, 4'h0);
    waitEdges(1);
    check("R4 faultN after edge 2", faultN, 4'h0);
    waitEdges(1);
    check("R4 faultN after edge 3", faultN, 4'hF);

    // Table walk, each vector held four edges
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][28], VEC[v][27:24], VEC[v][23:20], VEC[v][19:16],
            VEC[v][15:12], VEC[v][11:8]);
      waitEdges(4);
      check($sformatf("R1/R2/R5 faultN vec %0d", v), faultN, VEC[v][7:4]);
      check($sformatf("R6/R7 txSerOut vec %0d", v), txSerOut, VEC[v][3:0]);
    end

    // R3: single-flag latency, channel 2 density drops
    drive(1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0);
    waitEdges(4);
    densOk = 4'hB;
    waitEdges(2);
    check("R3 no change after 2 edges", faultN, 4'hF);
    waitEdges(1);
    check("R3 change on edge 3", faultN, 4'hB);

    // R6: loopback timing, forcing due on edge 2, fault qualification on edge 3
    drive(1'b0, 4'h0, 4'hF, 4'hF, 4'hF, 4'h2);
    waitEdges(4);
    check("R2 amp low before loopback", faultN, 4'h0);
    loopEn = 1'b1;
    waitEdges(1);
    check("R6 txSerOut after edge 1", txSerOut, 4'h2);
    waitEdges(1);
    check("R6 txSerOut after edge 2", txSerOut, 4'hF);
    check("R6 faultN after edge 2", faultN, 4'h0);
    waitEdges(1);
    check("R6 faultN after edge 3", faultN, 4'hF);

    // R7: pass-through is combinational
    loopEn = 1'b0;
    waitEdges(3);
    txSerIn = 4'h6;
    #1;
    check("R7 txSerOut same cycle", txSerOut, 4'h6);

    // R4: asynchronous reset clears faultN at once
    drive(1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h6);
    waitEdges(4);
    check("R1 good before reset", faultN, 4'hF);
    rstN = 1'b0;
    #1;
    check("R4 async reset", faultN, 4'h0);
    waitEdges(1);
    rstN = 1'b1;
    waitEdges(2);
    check("R4 still low after edge 2", faultN, 4'h0);
    waitEdges(1);
    check("R4 good after edge 3", faultN, 4'hF);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule